// File: doc/BRIEF.md
# Phase-Correct PWM Timer with Buffered Compare

This block is a 16-bit timer that counts from zero up to a selectable top value and back down again, one step per enable tick, and drives two PWM pins from this triangle count. Each pin has its own compare value. Its own two mode bits decide whether the pin is low, non-inverting or inverting. A clock-select field sets the tick rate through a free-running prescaler, or stops the count.

Software writes each compare value into a holding register. The value used for matching is updated from the holding register only at the upper turning point, so a write at any time cannot shorten or lengthen a pulse. A compare of zero and a compare equal to the top value each have their own output rules. An undivided clock with a compare at the top value leaves the pin untouched. The block sets an overflow flag at each lower turning point and one match flag per channel. It raises a request line for each flag when that flag's enable bit and the global enable are both set.

Top module: `pwm_pc_timer`

## Requirements
- R1: After reset the count, the control word, both holding registers, the match values, the flags, both pins and all request lines are zero.
- R2: Clock select (control bits 2:0) gives a tick on every clock for code 1. Codes 2, 3, 4 and 5 tick once per 8, 64, 256 and 1024 clocks, on the cycles where the low 3, 6, 8 or 10 bits of a free-running clock counter, zeroed at reset, are all ones. Codes 0, 6 and 7 give no tick.
- R3: On each tick the count steps by one. At zero it moves to 1 and turns upward. At or above the top value it moves down by one and turns downward. Otherwise it keeps its direction. The top value is 255, 511 or 1023 for resolution field (control bits 4:3) values 0, 1 and 2 or 3. The count is read at address 4.
- R4: A write to address 1 (channel A) or 2 (channel B) stores the data in that channel's holding register, and a read of that address returns the holding register from the next cycle on.
- R5: On a tick where the count is at or above the top value, each channel's match value takes its holding register. The compare on that tick uses the match value from before the update.
- R6: A match is a tick where the count equals the channel's match value. A match at zero is a down-count match, a match at the top value is an up-count match, and elsewhere the current direction decides. With mode 2 an up-count match drives the output low and a down-count match drives it high. Mode 3 does the opposite. Mode A sits in control bits 6:5 and mode B in bits 8:7.
- R7: With mode 0 or 1 the pin is held low. The channel's output level still follows the rules of mode bit 0.
- R8: A match with a match value of zero drives the output to mode bit 0, which gives a constant low for mode 2 and a constant high for mode 3.
- R9: A match with a match value equal to the top value drives the output to the inverse of mode bit 0 when clock select is not 1. When clock select is 1 it leaves the output unchanged.
- R10: The overflow flag (flag bit 0, address 3) is set on every tick where the count is zero.
- R11: The match flag of channel A (flag bit 1) and of channel B (flag bit 2) is set on every match of that channel.
- R12: Writing to address 3 clears each flag whose data bit is 1. A set on the same edge wins over the clear. The control word is read back at address 0.
- R13: Each request line (overflow, A, B) is high while its flag, its enable (control bits 9, 10, 11) and the global enable input are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| global_ie | input | 1 | Global request enable |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin |
| irq_ovf | output | 1 | Overflow request |
| irq_cmp_a | output | 1 | Channel A match request |
| irq_cmp_b | output | 1 | Channel B match request |

## Verification
Register writes, the count step, the match-value update, pin changes and flag sets all take effect on the clock edge that samples the write or the tick. The read data and the request lines follow combinationally from that state and from the inputs. The bench model takes the same inputs at each rising edge and updates its state at that edge. It then compares the pins, the request lines and the read data for the current address 1 ns after the edge. The idle address rotates through all five registers, so the count, the flags, the holding registers and the control word are each compared every fifth cycle.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned NUM_CH = 2;

   localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_CMP0  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_FLAGS = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd4;

   // control word: request enables, per-channel modes, resolution, clock select
   typedef struct packed {
      logic [NUM_CH:0]             irq_en;
      logic [NUM_CH-1:0][1:0]      out_mode;
      logic [1:0]                  res;
      logic [2:0]                  csel;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   function automatic logic [9:0] top_of(input logic [1:0] res);
      case (res)
         2'd0:    top_of = 10'h0FF;
         2'd1:    top_of = 10'h1FF;
         default: top_of = 10'h3FF;
      endcase
   endfunction
endpackage

// File: rtl/pwm_pc_prescale.sv
module pwm_pc_prescale #(
   parameter int unsigned PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] csel,
   output logic       tick,
   output logic       bypass
);
   localparam logic [PRE_W-1:0] STEP = PRE_W'(1);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;
   logic             run;

   initial begin
      assert (PRE_W >= 10) else $error("PRE_W must cover a 1024 divide");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + STEP;
   end

   always_comb begin
      run  = 1'b1;
      mask = '0;
      case (csel)
         3'd1: mask = '0;
         3'd2: mask = PRE_W'(7);
         3'd3: mask = PRE_W'(63);
         3'd4: mask = PRE_W'(255);
         3'd5: mask = PRE_W'(1023);
         default: run = 1'b0;
      endcase
   end

   assign tick   = run && ((pre_q & mask) == mask);
   assign bypass = (csel == 3'd1);
endmodule

// File: rtl/pwm_pc_updown.sv
module pwm_pc_updown #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic             at_bot,
   output logic             at_top,
   output logic             up_phase
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             dir_up_q;

   assign at_bot   = (cnt_q == '0);
   assign at_top   = !at_bot && (cnt_q >= top);
   assign up_phase = !at_bot && (at_top || dir_up_q);
   assign cnt      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         dir_up_q <= 1'b0;
      end else if (tick) begin
         if (at_bot) begin
            cnt_q    <= ONE;
            dir_up_q <= 1'b1;
         end else if (at_top) begin
            cnt_q    <= cnt_q - ONE;
            dir_up_q <= 1'b0;
         end else if (dir_up_q) begin
            cnt_q <= cnt_q + ONE;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   // R3
   hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

   // R3
   turn_down_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_top) |=> (!dir_up_q && !at_bot));
endmodule

// File: rtl/pwm_pc_channel.sv
module pwm_pc_channel #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] top,
   input  logic             at_top,
   input  logic             up_phase,
   input  logic             bypass,
   input  logic [1:0]       mode,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] shadow,
   output logic             match,
   output logic             pin
);
   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] active_q;
   logic             out_q;
   logic             out_nxt;

   assign match  = tick && (cnt == active_q);
   assign shadow = shadow_q;
   assign pin    = mode[1] ? out_q : 1'b0;

   always_comb begin
      out_nxt = out_q;
      if (match) begin
         if (active_q == '0)        out_nxt = mode[0];
         else if (active_q == top) begin
            if (!bypass)            out_nxt = !mode[0];
         end
         else if (up_phase)         out_nxt = mode[0];
         else                       out_nxt = !mode[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         active_q <= '0;
         out_q    <= 1'b0;
      end else begin
         if (wr)             shadow_q <= wdata;
         if (tick && at_top) active_q <= shadow_q;
         out_q <= out_nxt;
      end
   end

   // R4
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(shadow_q));

   // R5
   latch_only_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && at_top) |=> $stable(active_q));

   // R8
   zero_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && active_q == '0 && mode == 2'b10) |=> !out_q);
endmodule

// File: rtl/pwm_pc_timer.sv
module pwm_pc_timer
   import pwm_pc_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PRE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              global_ie,
   output logic              pwm_a,
   output logic              pwm_b,
   output logic              irq_ovf,
   output logic              irq_cmp_a,
   output logic              irq_cmp_b
);
   ctrl_t              ctrl_q;
   logic [NUM_CH:0]    flag_q;
   logic [NUM_CH:0]    flag_set;
   logic [NUM_CH:0]    flag_clr;
   logic [NUM_CH:0]    irq_vec;
   logic               tick;
   logic               bypass;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   top;
   logic               at_bot;
   logic               at_top;
   logic               up_phase;
   logic [NUM_CH-1:0]  match_v;
   logic [NUM_CH-1:0]  pin_v;
   logic [CNT_W-1:0]   shadow_arr [NUM_CH];

   initial begin
      assert (CNT_W >= CTRL_W) else $error("CNT_W too narrow for control word");
      assert (CNT_W >= 10) else $error("CNT_W too narrow for 10-bit top");
   end

   assign top = CNT_W'(top_of(ctrl_q.res));

   pwm_pc_prescale #(.PRE_W(PRE_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .csel(ctrl_q.csel), .tick(tick), .bypass(bypass)
   );

   pwm_pc_updown #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .top(top), .cnt(cnt),
      .at_bot(at_bot), .at_top(at_top), .up_phase(up_phase)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic wr_cmp;
      assign wr_cmp = bus_wr && (bus_addr == ADR_CMP0 + ADDR_W'(ch));
      pwm_pc_channel #(.CNT_W(CNT_W)) ch_i (
         .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .top(top),
         .at_top(at_top), .up_phase(up_phase), .bypass(bypass),
         .mode(ctrl_q.out_mode[ch]), .wr(wr_cmp), .wdata(bus_wdata),
         .shadow(shadow_arr[ch]), .match(match_v[ch]), .pin(pin_v[ch])
      );
   end

   assign flag_set = {match_v, tick && at_bot};
   assign flag_clr = (bus_wr && bus_addr == ADR_FLAGS) ? bus_wdata[NUM_CH:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= '0;
      end else begin
         if (bus_wr && bus_addr == ADR_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         flag_q <= (flag_q & ~flag_clr) | flag_set;
      end
   end

   assign irq_vec = flag_q & ctrl_q.irq_en & {(NUM_CH+1){global_ie}};

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_CTRL:  bus_rdata = CNT_W'(ctrl_q);
         ADR_FLAGS: bus_rdata = CNT_W'(flag_q);
         ADR_COUNT: bus_rdata = cnt;
         default:   bus_rdata = '0;
      endcase
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADR_CMP0 + ADDR_W'(i)) bus_rdata = shadow_arr[i];
      end
   end

   assign pwm_a     = pin_v[0];
   assign pwm_b     = pin_v[1];
   assign irq_ovf   = irq_vec[0];
   assign irq_cmp_a = irq_vec[1];
   assign irq_cmp_b = irq_vec[2];

   // R10
   ovf_from_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[0]) |-> $past(tick && at_bot));

   // R11
   cmp_a_from_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[1]) |-> $past(match_v[0]));
endmodule

// File: tb/pwm_pc_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_pc_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        global_ie = 1'b0;
   logic        pwm_a, pwm_b, irq_ovf, irq_cmp_a, irq_cmp_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int ra     = 0;

   // reference model state
   int pre_m, c_m, dir_m, ctl_m;
   int sh_m[2];
   int act_m[2];
   int out_m[2];
   int flg_m;
   int sel_v, res_v, top_v, mask_v, md_v, setv, clrv;
   bit run_v, tick_v, bot_v, attop_v, upph_v;

   always #2.5 clk = ~clk;

   pwm_pc_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .global_ie(global_ie),
      .pwm_a(pwm_a), .pwm_b(pwm_b), .irq_ovf(irq_ovf),
      .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int mk(int sel, int res, int ma, int mb, int en);
      return sel | (res << 3) | (ma << 5) | (mb << 7) | (en << 9);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pre_m = 0; c_m = 0; dir_m = 0; ctl_m = 0; flg_m = 0;
         for (int i = 0; i < 2; i++) begin sh_m[i] = 0; act_m[i] = 0; out_m[i] = 0; end
      end else begin
         sel_v = ctl_m & 7;
         res_v = (ctl_m >> 3) & 3;
         top_v = (res_v == 0) ? 255 : (res_v == 1) ? 511 : 1023;
         run_v = 1;
         case (sel_v)
            1: mask_v = 0;
            2: mask_v = 7;
            3: mask_v = 63;
            4: mask_v = 255;
            5: mask_v = 1023;
            default: begin mask_v = 0; run_v = 0; end
         endcase
         tick_v = run_v && ((pre_m & mask_v) == mask_v);
         setv = 0;
         if (tick_v) begin
            bot_v   = (c_m == 0);
            attop_v = !bot_v && (c_m >= top_v);
            upph_v  = !bot_v && (attop_v || dir_m == 1);
            for (int i = 0; i < 2; i++) begin
               md_v = (ctl_m >> (5 + 2*i)) & 3;
               if (c_m == act_m[i]) begin
                  setv |= (2 << i);
                  if (act_m[i] == 0) out_m[i] = md_v & 1;
                  else if (act_m[i] == top_v) begin
                     if (sel_v != 1) out_m[i] = 1 - (md_v & 1);
                  end
                  else if (upph_v) out_m[i] = md_v & 1;
                  else out_m[i] = 1 - (md_v & 1);
               end
            end
            if (attop_v) for (int i = 0; i < 2; i++) act_m[i] = sh_m[i];
            if (bot_v) begin setv |= 1; c_m = 1; dir_m = 1; end
            else if (attop_v) begin c_m = c_m - 1; dir_m = 0; end
            else if (dir_m == 1) c_m = c_m + 1;
            else c_m = c_m - 1;
         end
         clrv = 0;
         if (bus_wr) begin
            case (bus_addr)
               3'd0: ctl_m = bus_wdata & 16'h0FFF;
               3'd1: sh_m[0] = bus_wdata;
               3'd2: sh_m[1] = bus_wdata;
               3'd3: clrv = bus_wdata & 7;
               default: ;
            endcase
         end
         flg_m = (flg_m & ~clrv) | setv;
         pre_m = (pre_m + 1) % 1024;
      end
   end

   function automatic int exp_read(int a);
      case (a)
         0: return ctl_m;
         1: return sh_m[0];
         2: return sh_m[1];
         3: return flg_m;
         4: return c_m;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_pin(int ch);
      return (((ctl_m >> (6 + 2*ch)) & 1) != 0) ? out_m[ch] : 0;
   endfunction

   function automatic int exp_irq();
      return global_ie ? (flg_m & (ctl_m >> 9) & 7) : 0;
   endfunction

   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         case (bus_addr)
            3'd0: chk("R1 R12 control readback", bus_rdata, exp_read(0));
            3'd1, 3'd2: chk("R4 R5 holding register", bus_rdata, exp_read(bus_addr));
            3'd3: chk("R10 R11 R12 flags", bus_rdata, exp_read(3));
            default: chk("R2 R3 count", bus_rdata, exp_read(bus_addr));
         endcase
         chk("R6 R7 R8 R9 R5 pwm_a", pwm_a, exp_pin(0));
         chk("R6 R7 R8 R9 R5 pwm_b", pwm_b, exp_pin(1));
         chk("R13 requests", {irq_cmp_b, irq_cmp_a, irq_ovf}, exp_irq());
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         bus_wr = 1'b0;
         bus_addr = 3'(ra);
         ra = (ra + 1) % 5;
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset values seen at the ports while reset is held
      for (int a = 0; a < 5; a++) begin
         bus_addr = 3'(a);
         #1;
         chk("R1 reset register value", bus_rdata, 0);
      end
      chk("R1 reset pwm_a", pwm_a, 0);
      chk("R1 reset pwm_b", pwm_b, 0);
      chk("R1 reset requests", {irq_cmp_b, irq_cmp_a, irq_ovf}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(20);
      // R4: holding registers read back before any latch; clock stopped
      wr(1, 100);
      wr(2, 200);
      idle(10);
      global_ie = 1'b1;
      // non-inverting A, inverting B, undivided clock, all requests enabled
      wr(0, mk(1, 0, 2, 3, 7));
      idle(1200);
      wr(3, 7);
      idle(60);
      // R8 zero on A, R9 top on B with undivided clock
      wr(1, 0);
      wr(2, 255);
      idle(1100);
      // R9 top on B with divide-by-8
      wr(0, mk(2, 0, 2, 3, 7));
      idle(9000);
      // R13 global enable gating
      global_ie = 1'b0;
      idle(200);
      global_ie = 1'b1;
      wr(3, 7);
      idle(40);
      // R7 pin A disconnected, 9-bit resolution
      wr(0, mk(1, 1, 0, 2, 5));
      wr(1, 300);
      wr(2, 511);
      idle(2200);
      wr(2, 600);
      idle(1100);
      // R3 10-bit resolution, modes swapped
      wr(0, mk(1, 2, 3, 2, 3));
      wr(1, 5);
      wr(2, 1000);
      idle(4300);
      // R2 stop, then the slower dividers and the unused codes
      wr(0, mk(0, 2, 3, 2, 7));
      idle(300);
      wr(0, mk(3, 0, 2, 3, 7));
      idle(2000);
      wr(0, mk(4, 0, 2, 3, 7));
      idle(2600);
      wr(0, mk(5, 0, 2, 3, 7));
      idle(3000);
      wr(0, mk(6, 0, 2, 3, 7));
      idle(300);
      wr(0, mk(7, 0, 2, 3, 7));
      idle(300);
      // R12 clear racing a set: undivided clock, write clear every few cycles
      wr(0, mk(1, 0, 2, 3, 7));
      wr(1, 1);
      wr(2, 2);
      for (int k = 0; k < 300; k++) begin
         wr(3, k & 7);
         idle(1);
      end
      idle(600);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R3 watchdog expired actual=1 expected=0");
         finish_run();
      end
   end
endmodule